// File: doc/BRIEF.md
# Transmit DMA Channel Error Monitor

This block watches eight transmit DMA channels and gathers their status and error conditions into two registers that software reads and writes over a small register port. Each channel has a credit counter. Grant strobes raise it and word-sent strobes lower it. If the transmit FIFO reports full while that counter is not zero, the credit accounting has lost step with the FIFO, and the block flags it.

Each channel also has a one-entry request slot. An activation command fills the slot, and a done strobe empties it. An activation that arrives while the slot is still full is flagged as an overlap.

Two global conditions are also latched: a bad internal memory address, and a host transfer that delivered the wrong dword count. Every error bit stays set until software writes 1 to it. An interrupt line is raised while any error bit is set. The block moves no data and does not schedule anything.

Top module: `tdm_err_monitor`

## Requirements
- R1: Each channel's credit counter starts at 0 after reset. In a cycle, a grant alone adds 1, a word-sent alone subtracts 1, and both together or neither leave it unchanged. The counter saturates at its maximum (2^CREDIT_W - 1) and at 0.
- R2: A FIFO-full strobe on channel i sets error bit i (bits 7:0) when that channel's credit counter is nonzero in that cycle. With a zero counter it sets nothing.
- R3: An activation strobe fills channel i's request slot. A done strobe empties it. An activation while the slot is full sets error bit 9+i (bits 16:9), unless a done strobe for that channel arrives in the same cycle; in that case the slot is refilled with no error.
- R4: An address-error strobe sets error bit 31. A dword-count-error strobe sets error bit 30.
- R5: Error bits are sticky and are cleared only by writing 1 to them at register address 1. Writing 0 has no effect. Bits 8 and 29:17 always read 0.
- R6: When a set event and a write-1 clear hit the same error bit in one cycle, the bit ends up set.
- R7: irq_o is 1 exactly when any error bit is set.
- R8: A read strobe captures the selected register into reg_rdata_o at the next clock edge; reg_rdata_o holds at other times. Address 0 returns the status register: bits 31:24 are buf_empty_i, bits 23:16 are 1 for each channel whose request slot is empty, and the rest are 0. Address 1 returns the error register. Addresses 2 and 3 return 0.
- R9: chan_idle_o[i] is 1 when buf_empty_i[i] is 1 and channel i's request slot is empty.
- R10: A synchronous active-low reset clears all counters, slots, error bits and reg_rdata_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| credit_grant_i | input | 8 | Per-channel credit grant strobe |
| word_sent_i | input | 8 | Per-channel word-sent strobe |
| fifo_full_i | input | 8 | Per-channel transmit FIFO full strobe |
| act_cmd_i | input | 8 | Per-channel activation command strobe |
| req_done_i | input | 8 | Per-channel request-slot release strobe |
| buf_empty_i | input | 8 | Per-channel buffers-empty level |
| addr_err_i | input | 1 | Internal memory address error strobe |
| dword_err_i | input | 1 | Host dword count mismatch strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| chan_idle_o | output | 8 | Per-channel idle indication |
| irq_o | output | 1 | Any error bit set |

## Verification
The credit counters and request slots cannot be read directly. A wrong counter therefore shows up only when a FIFO-full strobe arrives: a missing or spurious credit-error bit appears on the next read of the error register, and irq_o changes one edge after the strobe. A wrong request-slot state shows up in the same cycle on chan_idle_o, and also in the no-pending field of the next status read. The bench runs a behavioural model alongside the design and compares idle, interrupt and read data after every edge, so a bad state is caught within one cycle of becoming visible.

// File: rtl/tdm_pkg.sv
// Package: shared layout constants for the transmit DMA error monitor.
// Assumes a fixed channel count of 8, because the register bit layout depends on it.
package tdm_pkg;
    localparam int TDM_NCH        = 8;
    localparam int TDM_REG_W      = 32;
    localparam int TDM_CRERR_LSB  = 0;
    localparam int TDM_OVL_LSB    = 9;
    localparam int TDM_DWERR_BIT  = 30;
    localparam int TDM_ADERR_BIT  = 31;
    localparam int TDM_NOPEND_LSB = 16;
    localparam int TDM_EMPTY_LSB  = 24;

    typedef enum logic [1:0] {
        TDM_REG_STATUS = 2'd0,
        TDM_REG_ERROR  = 2'd1
    } tdm_reg_e;

    // Mask of the implemented error bits.
    function automatic logic [TDM_REG_W-1:0] tdm_err_mask();
        logic [TDM_REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < TDM_NCH; i++) begin
            m[TDM_CRERR_LSB + i] = 1'b1;
            m[TDM_OVL_LSB + i]   = 1'b1;
        end
        m[TDM_DWERR_BIT] = 1'b1;
        m[TDM_ADERR_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/tdm_credit_ctr.sv
// Module: per-channel credit counter with a desynchronisation detector.
// Raises desync_o in the cycle when FIFO full is seen while the count is nonzero.
// Assumes the strobes are single-cycle and synchronous to clk.
module tdm_credit_ctr #(
    parameter int CREDIT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic sent_i,
    input  logic full_i,
    output logic desync_o
);
    localparam logic [CREDIT_W-1:0] CNT_MAX = {CREDIT_W{1'b1}};

    logic [CREDIT_W-1:0] cnt_q;

    // Count grants up and sent words down, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (grant_i && !sent_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (sent_i && !grant_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag a full indication that arrives with outstanding credit.
    always_comb desync_o = full_i && (cnt_q != '0);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && grant_i && !sent_i) |=> (cnt_q == CNT_MAX));
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && sent_i && !grant_i) |=> (cnt_q == '0));
    assert_balanced_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && sent_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tdm_req_slot.sv
// Module: per-channel one-entry request slot tracker.
// An activation fills the slot and a done strobe empties it. Activating a full slot
// (with no done in the same cycle) raises overlap_o for that cycle.
module tdm_req_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic done_i,
    output logic busy_o,
    output logic overlap_o
);
    logic busy_q;

    // Track occupancy; a release and a refill in the same cycle leave the slot full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= act_i || (busy_q && !done_i);
        end
    end

    // Report an activation that lands on a slot still holding a command.
    always_comb overlap_o = act_i && busy_q && !done_i;

    always_comb busy_o = busy_q;

    assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> busy_o);
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !act_i) |=> !busy_o);
endmodule

// File: rtl/tdm_err_w1c.sv
// Module: sticky error register with write-1-to-clear.
// A set wins over a clear on the same bit. Bits outside MASK are held at zero.
module tdm_err_w1c #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] err_o,
    output logic         any_o
);
    logic [W-1:0] err_q;

    // Accumulate set events and drop bits written with 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= ((err_q & ~clr_i) | set_i) & MASK;
        end
    end

    // Expose the register and its reduction.
    always_comb begin
        err_o = err_q;
        any_o = |err_q;
    end

    for (genvar b = 0; b < W; b++) begin : g_chk
        if (MASK[b]) begin : g_live
            assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[b] |=> err_o[b]);
            assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (err_o[b] && !clr_i[b]) |=> err_o[b]);
        end
    end

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_o) |-> $past(|(set_i & MASK)));
endmodule

// File: rtl/tdm_err_monitor.sv
// Module: transmit DMA channel status and error monitor (top).
// Builds a status word (buffers empty, no request pending) and a sticky W1C
// error word from the per-channel credit and request-slot trackers, plus two
// global error strobes. Read data is registered on the read strobe.
module tdm_err_monitor
    import tdm_pkg::*;
#(
    parameter int CREDIT_W = 8,
    parameter int ADDR_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TDM_NCH-1:0]   credit_grant_i,
    input  logic [TDM_NCH-1:0]   word_sent_i,
    input  logic [TDM_NCH-1:0]   fifo_full_i,
    input  logic [TDM_NCH-1:0]   act_cmd_i,
    input  logic [TDM_NCH-1:0]   req_done_i,
    input  logic [TDM_NCH-1:0]   buf_empty_i,
    input  logic                 addr_err_i,
    input  logic                 dword_err_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [TDM_REG_W-1:0] reg_wdata_i,
    input  logic                 reg_rd_i,
    output logic [TDM_REG_W-1:0] reg_rdata_o,
    output logic [TDM_NCH-1:0]   chan_idle_o,
    output logic                 irq_o
);
    localparam logic [TDM_REG_W-1:0] ERR_MASK = tdm_err_mask();
    localparam logic [ADDR_W-1:0]    A_STAT   = ADDR_W'(TDM_REG_STATUS);
    localparam logic [ADDR_W-1:0]    A_ERR    = ADDR_W'(TDM_REG_ERROR);

    logic [TDM_NCH-1:0]   desync;
    logic [TDM_NCH-1:0]   overlap;
    logic [TDM_NCH-1:0]   busy;
    logic [TDM_REG_W-1:0] err_set;
    logic [TDM_REG_W-1:0] err_clr;
    logic [TDM_REG_W-1:0] err_word;
    logic [TDM_REG_W-1:0] stat_word;
    logic [TDM_REG_W-1:0] rdata_q;

    for (genvar c = 0; c < TDM_NCH; c++) begin : g_ch
        tdm_credit_ctr #(.CREDIT_W(CREDIT_W)) u_credit (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant_i  (credit_grant_i[c]),
            .sent_i   (word_sent_i[c]),
            .full_i   (fifo_full_i[c]),
            .desync_o (desync[c])
        );
        tdm_req_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_cmd_i[c]),
            .done_i    (req_done_i[c]),
            .busy_o    (busy[c]),
            .overlap_o (overlap[c])
        );
    end

    // Place the per-channel and global events at their error bit positions.
    always_comb begin
        err_set = '0;
        for (int i = 0; i < TDM_NCH; i++) begin
            err_set[TDM_CRERR_LSB + i] = desync[i];
            err_set[TDM_OVL_LSB + i]   = overlap[i];
        end
        err_set[TDM_DWERR_BIT] = dword_err_i;
        err_set[TDM_ADERR_BIT] = addr_err_i;
    end

    // Turn a write to the error address into a per-bit clear vector.
    always_comb err_clr = (reg_wr_i && reg_addr_i == A_ERR) ? reg_wdata_i : '0;

    tdm_err_w1c #(.W(TDM_REG_W), .MASK(ERR_MASK)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (err_clr),
        .err_o (err_word),
        .any_o (irq_o)
    );

    // Assemble the status word from buffer-empty levels and free request slots.
    always_comb begin
        stat_word = '0;
        stat_word[TDM_EMPTY_LSB  +: TDM_NCH] = buf_empty_i;
        stat_word[TDM_NOPEND_LSB +: TDM_NCH] = ~busy;
    end

    // A channel is idle when its buffers are empty and nothing is pending.
    always_comb chan_idle_o = buf_empty_i & ~busy;

    // Capture the addressed register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_i) begin
            if (reg_addr_i == A_STAT)      rdata_q <= stat_word;
            else if (reg_addr_i == A_ERR)  rdata_q <= err_word;
            else                           rdata_q <= '0;
        end
    end

    always_comb reg_rdata_o = rdata_q;

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> $stable(reg_rdata_o));
    assert_overlap_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|overlap) |=> irq_o);
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == A_ERR) |=> (reg_rdata_o & ~ERR_MASK) == '0);
endmodule

// File: tb/tb_tdm_err_monitor.sv
// Bench: behavioural reference model compared after every clock edge, plus
// scenario checks with hand-computed expected values.
module tb_tdm_err_monitor;
    localparam int CW   = 3;
    localparam int CMAX = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  grant = '0, sent = '0, full = '0, act = '0, done = '0, bempty = '0;
    logic        aerr = 1'b0, derr = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  idle;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    int          m_cred [8];
    bit          m_busy [8];
    logic [31:0] m_err   = '0;
    logic [31:0] m_rdata = '0;

    always #4 clk = ~clk;

    tdm_err_monitor #(.CREDIT_W(CW), .ADDR_W(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .credit_grant_i(grant), .word_sent_i(sent), .fifo_full_i(full),
        .act_cmd_i(act), .req_done_i(done), .buf_empty_i(bempty),
        .addr_err_i(aerr), .dword_err_i(derr),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
        .reg_rdata_o(rdata), .chan_idle_o(idle), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[31:24] = bempty;
        for (int i = 0; i < 8; i++) s[16+i] = !m_busy[i];
        return s;
    endfunction

    // One clock: advance the model at the edge, then compare at the falling edge.
    task automatic tick();
        logic [31:0] setv;
        logic [31:0] clrv;
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_cred[i] = 0; m_busy[i] = 0; end
            m_err = '0; m_rdata = '0;
        end else begin
            setv = '0;
            for (int i = 0; i < 8; i++) begin
                if (full[i] && m_cred[i] != 0) setv[i] = 1'b1;
                if (act[i] && m_busy[i] && !done[i]) setv[9+i] = 1'b1;
            end
            setv[31] = aerr; setv[30] = derr;
            if (rd) m_rdata = (addr == 0) ? m_status() : (addr == 1) ? m_err : 32'h0;
            clrv = (wr && addr == 1) ? wdata : 32'h0;
            m_err = ((m_err & ~clrv) | setv) & 32'hC001FEFF;
            for (int i = 0; i < 8; i++) begin
                if (grant[i] && !sent[i] && m_cred[i] < CMAX) m_cred[i]++;
                else if (sent[i] && !grant[i] && m_cred[i] > 0) m_cred[i]--;
                m_busy[i] = act[i] || (m_busy[i] && !done[i]);
            end
        end
        @(negedge clk);
        check("R8 model rdata", rdata, m_rdata);
        check("R7 model irq", {31'b0, irq}, {31'b0, m_err != 0});
        begin
            logic [7:0] ei;
            for (int i = 0; i < 8; i++) ei[i] = bempty[i] && !m_busy[i];
            check("R9 model idle", {24'b0, idle}, {24'b0, ei});
        end
        grant = '0; sent = '0; full = '0; act = '0; done = '0;
        aerr = 0; derr = 0; wr = 0; rd = 0; wdata = '0; addr = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a);
        addr = a; rd = 1'b1; tick();
    endtask

    task automatic wr_reg(input logic [31:0] d);
        addr = 2'd1; wr = 1'b1; wdata = d; tick();
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bempty = 8'hFF;
        @(negedge clk);
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1;
        // R10: reset state
        check("R10 rdata", rdata, 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);
        check("R10 idle", {24'b0, idle}, 32'hFF);
        rd_reg(2'd0);
        check("R10 status after reset", rdata, 32'hFFFF0000);

        // R2: ch2 credit nonzero then full
        repeat (3) begin grant[2] = 1; tick(); end
        full[2] = 1; tick();
        rd_reg(2'd1);
        check("R2 credit error ch2", rdata, 32'h00000004);
        // R2: zero-credit full on ch5 has no effect
        full[5] = 1; tick();
        rd_reg(2'd1);
        check("R2 zero credit ignored", rdata, 32'h00000004);

        // R1: saturate high at 7, drain 7, counter reaches zero
        repeat (10) begin grant[0] = 1; tick(); end
        repeat (7) begin sent[0] = 1; tick(); end
        full[0] = 1; tick();
        rd_reg(2'd1);
        check("R1 saturation then drain", rdata, 32'h00000004);
        repeat (3) begin sent[0] = 1; tick(); end
        grant[0] = 1; tick();
        grant[0] = 1; sent[0] = 1; tick();
        full[0] = 1; tick();
        rd_reg(2'd1);
        check("R1 low saturation and balanced hold", rdata, 32'h00000005);

        // R5: writing 0 does nothing, writing 1 clears
        wr_reg(32'h0);
        rd_reg(2'd1);
        check("R5 write zero", rdata, 32'h00000005);
        wr_reg(32'h1);
        rd_reg(2'd1);
        check("R5 partial clear", rdata, 32'h00000004);
        wr_reg(32'hFFFFFFFF);
        check("R7 irq low after clear", {31'b0, irq}, 32'h0);

        // R3 / R9: slot fill, overlap, refill with release
        act[3] = 1; tick();
        check("R9 idle with busy slot", {24'b0, idle}, 32'hF7);
        rd_reg(2'd0);
        check("R8 status busy ch3", rdata, 32'hFFF70000);
        act[3] = 1; tick();
        rd_reg(2'd1);
        check("R3 overlap ch3", rdata, 32'h00001000);
        wr_reg(32'h00001000);
        act[3] = 1; done[3] = 1; tick();
        rd_reg(2'd1);
        check("R3 refill with release", rdata, 32'h0);
        check("R3 still busy", {24'b0, idle}, 32'hF7);
        done[3] = 1; tick();
        check("R3 released", {24'b0, idle}, 32'hFF);

        // R4 and R7
        aerr = 1; derr = 1; tick();
        check("R7 irq set", {31'b0, irq}, 32'h1);
        rd_reg(2'd1);
        check("R4 global errors", rdata, 32'hC0000000);

        // R6: set and clear collide on bit 31
        addr = 2'd1; wr = 1; wdata = 32'hC0000000; aerr = 1; tick();
        rd_reg(2'd1);
        check("R6 set wins", rdata, 32'h80000000);

        // R5/R8: reserved bits, unused addresses, status layout
        wr_reg(32'hFFFFFFFF);
        rd_reg(2'd1);
        check("R5 all cleared", rdata, 32'h0);
        rd_reg(2'd2);
        check("R8 address 2 reads 0", rdata, 32'h0);
        bempty = 8'h0F;
        act[1] = 1; tick();
        rd_reg(2'd0);
        check("R8 status layout", rdata, 32'h0FFD0000);
        check("R9 idle pattern", {24'b0, idle}, 32'h0D);
        tick(); tick();
        check("R8 rdata holds", rdata, 32'h0FFD0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule